// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns activity on three external request pins into interrupt requests for a processor. Two pins are sampled in the system clock domain. Each has a two-bit sense mode that picks low level, any change, falling edge or rising edge. The third pin is captured on an edge without the system clock. A single polarity bit selects whether that edge is falling or rising. The captured event then crosses into the clock domain through a synchronizer.

Edge events set a sticky pending flag for their channel. In low-level mode no flag is set, and the request follows the synchronized pin directly. A channel's request output is raised only when its mask bit and the global enable are both set. Software programs the sense and mask registers through a small register port and clears flags by writing ones. A hardware acknowledge clears the flag of the channel the processor has just serviced.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, the sense register, the mask register and the pending flags read as zero, and every request output is low.
- R2: Sense mode 00 (low level): the request follows the synchronized pin while it is low and drops once the pin returns high. The channel's pending flag stays clear.
- R3: Sense mode 01 (any change): both a rising and a falling transition of the synchronized pin set the channel's pending flag.
- R4: Sense mode 10 (falling edge): a falling transition sets the flag, and a rising transition leaves it clear.
- R5: Sense mode 11 (rising edge): a rising transition sets the flag, and a falling transition leaves it clear.
- R6: On the asynchronous channel (flag bit 2), polarity 0 catches falling edges and polarity 1 catches rising edges. The opposite edge sets nothing. The flag appears after two synchronizer stages.
- R7: Changing the asynchronous polarity bit from 0 to 1 while that pin is high is seen as an edge and sets flag bit 2.
- R8: Request bit i is high only when mask bit i and the global enable are both high.
- R9: Writing the flag register (address 2) clears each flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R10: A hardware acknowledge with a channel number clears only that channel's flag.
- R11: When a new event and a clear (write or acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R12: Register map: address 0 holds the sense modes in bits [1:0] (channel 0) and [3:2] (channel 1) and the polarity in bit 4. Address 1 holds the mask in bits [2:0], and address 2 holds the flags in bits [2:0]. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_sync | input | 2 | Clock-domain request pins, channels 0 and 1 |
| pin_async | input | 1 | Edge-captured request pin, channel 2 |
| glob_en | input | 1 | Global interrupt enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 5 | Register write data |
| reg_rdata | output | 5 | Register read data (combinational) |
| ack_valid | input | 1 | Hardware acknowledge strobe |
| ack_chan | input | 2 | Channel being acknowledged |
| irq_req | output | 3 | Per-channel interrupt request |

## Verification
The embedded properties check several rules on every cycle. Requests are gated by the mask and the global enable, and a flag never rises in level mode. A clear empties a flag unless an event arrived in the same cycle, a new event always leaves the flag set, and writing zero leaves a flag alone. Other behaviour can only be shown by the directed scenarios: the exact edge each sense mode accepts, the asynchronous polarity choice, the spurious flag caused by a polarity change, the exact-cycle collision between a write-one-to-clear and an edge, and the register read-back map.

// File: rtl/ext_irq_sense.sv
module ext_irq_sense #(
  parameter int SYNC_CH = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [SYNC_CH-1:0]           pin_sync,
  input  logic                         pin_async,
  input  logic                         glob_en,
  input  logic                         reg_wr,
  input  logic [1:0]                   reg_addr,
  input  logic [2*SYNC_CH:0]           reg_wdata,
  output logic [2*SYNC_CH:0]           reg_rdata,
  input  logic                         ack_valid,
  input  logic [$clog2(SYNC_CH+1)-1:0] ack_chan,
  output logic [SYNC_CH:0]             irq_req
);
  localparam int NCH = SYNC_CH + 1;
  localparam int SW  = 2 * SYNC_CH;
  localparam int RW  = SW + 1;

  logic [SW-1:0]      mode_q;
  logic               pol_q;
  logic [NCH-1:0]     mask_q, flag_q;
  logic [SYNC_CH-1:0] s1, s2, s3;
  logic               at_tog, at_s1, at_s2, at_s3;
  logic [NCH-1:0]     ev, lvl, clr;
  logic               xpin;

  wire wr_sense = reg_wr && (reg_addr == 2'd0);
  wire wr_mask  = reg_wr && (reg_addr == 2'd1);
  wire wr_flag  = reg_wr && (reg_addr == 2'd2);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= '0;
      pol_q  <= 1'b0;
      mask_q <= '0;
    end else begin
      if (wr_sense) {pol_q, mode_q} <= reg_wdata;
      if (wr_mask)  mask_q <= reg_wdata[NCH-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s3, s2, s1} <= '1;
    else        {s3, s2, s1} <= {s2, s1, pin_sync};

  assign xpin = pin_async ~^ pol_q;

  always_ff @(posedge xpin or negedge rst_n)
    if (!rst_n) at_tog <= 1'b0;
    else        at_tog <= ~at_tog;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {at_s3, at_s2, at_s1} <= '0;
    else        {at_s3, at_s2, at_s1} <= {at_s2, at_s1, at_tog};

  always_comb begin
    ev  = '0;
    lvl = '0;
    for (int i = 0; i < SYNC_CH; i++) begin
      case (mode_q[2*i +: 2])
        2'b00:   lvl[i] = ~s2[i];
        2'b01:   ev[i]  = s2[i] ^ s3[i];
        2'b10:   ev[i]  = s3[i] & ~s2[i];
        default: ev[i]  = s2[i] & ~s3[i];
      endcase
    end
    ev[NCH-1] = at_s2 ^ at_s3;
  end

  assign clr = (wr_flag ? reg_wdata[NCH-1:0] : '0)
             | (ack_valid ? (NCH'(1) << ack_chan) : '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag_q <= '0;
    else        flag_q <= ev | (flag_q & ~clr);

  assign irq_req = {NCH{glob_en}} & mask_q & (flag_q | lvl);

  always_comb
    case (reg_addr)
      2'd0:    reg_rdata = {pol_q, mode_q};
      2'd1:    reg_rdata = RW'(mask_q);
      2'd2:    reg_rdata = RW'(flag_q);
      default: reg_rdata = '0;
    endcase

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & ~(mask_q & {NCH{glob_en}})) == '0);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev[g] |=> flag_q[g]);
    // R9
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_flag && reg_wdata[g] && !ev[g]) |=> !flag_q[g]);
    // R9
    w0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[g] && !(wr_flag && reg_wdata[g]) && !(ack_valid && ack_chan == g)) |=> flag_q[g]);
    // R10
    ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_chan == g && !ev[g]) |=> !flag_q[g]);
  end

  for (genvar g = 0; g < SYNC_CH; g++) begin : g_lvl
    // R2
    lvl_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2*g +: 2] == 2'b00 && !flag_q[g] && !wr_sense) |=> !flag_q[g]);
  end
endmodule

// File: tb/ext_irq_sense_tb.sv
module ext_irq_sense_tb_top;
  logic       clk = 0, rst_n = 0;
  logic [1:0] pin_sync = 2'b11;
  logic       pin_async = 1, glob_en = 0, reg_wr = 0, ack_valid = 0;
  logic [1:0] reg_addr = 0, ack_chan = 0;
  logic [4:0] reg_wdata = 0, reg_rdata;
  logic [2:0] irq_req;
  int checks = 0, errors = 0;

  ext_irq_sense dut_i (.clk, .rst_n, .pin_sync, .pin_async, .glob_en, .reg_wr,
    .reg_addr, .reg_wdata, .reg_rdata, .ack_valid, .ack_chan, .irq_req);

  always #5 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [4:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [4:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic flags_is(string tag, logic [2:0] exp);
    logic [4:0] d;
    rd(2, d); chk(tag, d, {2'b0, exp});
  endtask

  task automatic t_reset;
    logic [4:0] d;
    rd(0, d); chk("R1 sense", d, 0);
    rd(1, d); chk("R1 mask", d, 0);
    rd(2, d); chk("R1 flags", d, 0);
    chk("R1 irq", irq_req, 0);
    rd(3, d); chk("R12 addr3", d, 0);
  endtask

  task automatic t_level;
    glob_en = 1; wr(1, 5'b00001); wr(0, 5'b00000);
    @(negedge clk); pin_sync[0] = 0; wait_n(3);
    chk("R2 irq low", irq_req[0], 1);
    flags_is("R2 no flag", 3'b000);
    pin_sync[0] = 1; wait_n(3);
    chk("R2 irq drop", irq_req[0], 0);
  endtask

  task automatic t_any;
    logic [4:0] d;
    wr(0, 5'b00001); rd(0, d); chk("R12 sense rb", d, 5'b00001);
    @(negedge clk); pin_sync[0] = 0; wait_n(4);
    flags_is("R3 fall", 3'b001);
    chk("R8 irq on", irq_req[0], 1);
    wr(2, 5'b00001); flags_is("R9 clear", 3'b000);
    pin_sync[0] = 1; wait_n(4);
    flags_is("R3 rise", 3'b001);
    wr(2, 5'b00001);
  endtask

  task automatic t_edges;
    wr(0, 5'b01000);
    @(negedge clk); pin_sync[1] = 0; wait_n(4);
    flags_is("R4 fall", 3'b010); wr(2, 5'b00010);
    pin_sync[1] = 1; wait_n(4);
    flags_is("R4 rise ignored", 3'b000);
    wr(0, 5'b01100);
    pin_sync[1] = 0; wait_n(4);
    flags_is("R5 fall ignored", 3'b000);
    pin_sync[1] = 1; wait_n(4);
    flags_is("R5 rise", 3'b010); wr(2, 5'b00010);
  endtask

  task automatic t_async;
    wr(0, 5'b00000);
    @(negedge clk); pin_async = 0; wait_n(4);
    flags_is("R6 pol0 fall", 3'b100); wr(2, 5'b00100);
    pin_async = 1; wait_n(4);
    flags_is("R6 pol0 rise ignored", 3'b000);
    pin_async = 0; wait_n(4); wr(2, 5'b00100);
    wr(0, 5'b10000); wait_n(4);
    flags_is("R6 pol change low pin", 3'b000);
    pin_async = 1; wait_n(4);
    flags_is("R6 pol1 rise", 3'b100); wr(2, 5'b00100);
    pin_async = 0; wait_n(4);
    flags_is("R6 pol1 fall ignored", 3'b000);
    pin_async = 1; wait_n(4); wr(2, 5'b00100);
  endtask

  task automatic t_polchg;
    wr(0, 5'b00000); wait_n(4); wr(2, 5'b00100);
    flags_is("R7 pre", 3'b000);
    wr(0, 5'b10000); wait_n(4);
    flags_is("R7 spurious", 3'b100);
    chk("R8 mask off", irq_req[2], 0);
    wr(1, 5'b00100); chk("R8 mask on", irq_req[2], 1);
    glob_en = 0; #1 chk("R8 gie off", irq_req, 0);
    glob_en = 1;
  endtask

  task automatic t_w1c_ack;
    wr(0, 5'b10001);
    @(negedge clk); pin_sync[0] = 0; wait_n(4);
    flags_is("R9 setup", 3'b101);
    wr(2, 5'b00000); flags_is("R9 write zero", 3'b101);
    @(negedge clk); ack_valid = 1; ack_chan = 0;
    @(negedge clk); ack_valid = 0;
    flags_is("R10 ack ch0", 3'b100);
    @(negedge clk); ack_valid = 1; ack_chan = 2;
    @(negedge clk); ack_valid = 0;
    flags_is("R10 ack ch2", 3'b000);
  endtask

  task automatic t_prio;
    @(negedge clk); pin_sync[0] = ~pin_sync[0];
    @(negedge clk);
    @(negedge clk); reg_wr = 1; reg_addr = 2; reg_wdata = 5'b00001;
    @(negedge clk); reg_wr = 0;
    flags_is("R11 set wins w1c", 3'b001);
    wr(2, 5'b00001);
    @(negedge clk); pin_sync[0] = ~pin_sync[0];
    @(negedge clk);
    @(negedge clk); ack_valid = 1; ack_chan = 0;
    @(negedge clk); ack_valid = 0;
    flags_is("R11 set wins ack", 3'b001);
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_n(3); rst_n = 1; wait_n(2);
    t_reset; t_level; t_any; t_edges; t_async; t_polchg; t_w1c_ack; t_prio;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule